// File: doc/BRIEF.md
# Translation Buffer with Page-Table Walk

This block converts virtual addresses into physical addresses for a paged memory with a single-level page table. A small fully associative buffer holds recently used translations, looked up by virtual page number. When the page is present, the physical frame is joined with the unchanged page offset and the result is returned one cycle after the request is accepted. When it is absent, the block fetches the page-table entry from memory itself, checks it, keeps a copy in the buffer and then answers.

Every access carries a kind: read, write or instruction fetch. Each page-table entry carries a valid flag and three rights flags. Accesses beyond the table length, to pages marked not present, or of a kind the page does not allow come back as faults with a code. Two free-running counters record lookups served from the buffer and table reads started, so that a hit ratio can be formed outside the block. A flush input empties the buffer. It must be pulsed whenever the table base changes.

Top module: `xlat_unit`

## Requirements
- R1: A translated address is the 20-bit frame number from the entry in bits 31:12, followed by bits 11:0 of the virtual address passed through unchanged.
- R2: A request whose page is held in the buffer is answered with `rsp_valid` one cycle after acceptance, without any table read.
- R3: On a buffer miss the block reads the word at `pt_base + 4*page` and answers in the cycle after `pt_rd_done`. A valid entry is kept, so a later access to that page is served from the buffer even if memory has since changed.
- R4: A page number not below `pt_len` faults with code 1 in the cycle after acceptance. It starts no table read and leaves both counters unchanged.
- R5: An entry with bit 0 (valid) clear faults with code 2 and is not kept in the buffer. A repeat access reads the table again.
- R6: Entry bits 1, 2 and 3 permit read (kind 0), write (kind 1) and fetch (kind 2). Kind 3 is never permitted. A disallowed access faults with code 3 on both the hit and the miss path, using the rights stored with the buffer entry. `rsp_paddr` is zero on every fault, and code 0 means success.
- R7: `flush` empties the whole buffer in one cycle. A request accepted in the same cycle as `flush` is treated as a miss.
- R8: With 16 buffer entries, fills replace slots in round-robin order, so the 17th distinct fill evicts the oldest entry.
- R9: `hit_count` rises by one for each accepted in-range request served from the buffer. `miss_count` rises by one for each table read started.
- R10: After reset, `rsp_valid`, `pt_rd_valid` and both counters are zero, and `req_ready` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every buffer entry |
| pt_base | input | 32 | Byte address of page-table word 0 |
| pt_len | input | 21 | Number of legal pages |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 ok, 1 out of range, 2 not present, 3 rights |
| pt_rd_valid | output | 1 | Table read pending, held until done |
| pt_rd_addr | output | 32 | Table word address |
| pt_rd_done | input | 1 | Table read data present |
| pt_rd_data | input | 32 | Page-table entry |
| hit_count | output | 16 | Lookups served from the buffer |
| miss_count | output | 16 | Table reads started |

## Verification
Two events can meet in one cycle: a flush and the lookup of a page that is currently held in the buffer. The bench drives `flush` and the request on the same falling edge for a page it has just filled. The flush must win, so the access is counted as a miss and the entry is read again from memory. This is confirmed with the counters and with a table entry that was changed in memory beforehand, so a stale hit would return the old frame. The same stale-entry technique shows eviction order and that buffer hits ignore memory.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        F_NONE    = 2'd0,
        F_BOUND   = 2'd1,
        F_INVALID = 2'd2,
        F_RIGHTS  = 2'd3
    } fault_e;

    // order matches entry bits 3:1
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  acc_kind_e kind,
    input  perm_t     perm,
    output logic      ok
);
    always_comb begin
        case (kind)
            ACC_READ:  ok = perm.r;
            ACC_WRITE: ok = perm.w;
            ACC_FETCH: ok = perm.x;
            default:   ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlat_ctr.sv
module xlat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] n;
    } ctr_t;

    ctr_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d.n = cnt_q.n + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.n;

    // R9
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
    // R9
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output perm_t            lk_perm,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn,
    input  perm_t            ins_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]   rr;
    } cam_t;

    cam_t cam_d, cam_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = cam_q.ent[g].v && (cam_q.ent[g].vpn == lk_vpn) && !flush;
    end

    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_pfn  = lk_pfn | cam_q.ent[i].pfn;
                lk_perm = lk_perm | cam_q.ent[i].perm;
            end
        end
    end
    assign lk_hit = |match;

    always_comb begin
        cam_d = cam_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) cam_d.ent[i].v = 1'b0;
        end else if (ins_en) begin
            cam_d.ent[cam_q.rr] = '{v: 1'b1, vpn: ins_vpn, pfn: ins_pfn, perm: ins_perm};
            cam_d.rr = (cam_q.rr == LAST) ? '0 : cam_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cam_q <= '0;
        else        cam_q <= cam_d;
    end

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [PA_W-1:0]        pt_base,
    input  logic [VA_W-OFF_W:0]    pt_len,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_kind,
    output logic                   rsp_valid,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [1:0]             rsp_fault,
    output logic                   pt_rd_valid,
    output logic [PA_W-1:0]        pt_rd_addr,
    input  logic                   pt_rd_done,
    input  logic [PA_W-1:0]        pt_rd_data,
    output logic [CNT_W-1:0]       hit_count,
    output logic [CNT_W-1:0]       miss_count
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;

    typedef enum logic {S_IDLE, S_WALK} st_e;

    typedef struct packed {
        st_e              st;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
        acc_kind_e        kind;
        logic             rv;
        logic [PA_W-1:0]  pa;
        fault_e           flt;
        logic [PA_W-1:0]  ptaddr;
    } unit_t;

    unit_t u_d, u_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    acc_kind_e        req_k;
    logic             lk_hit, lk_ok, wk_ok;
    logic [PFN_W-1:0] lk_pfn;
    perm_t            lk_perm, wk_perm;
    logic [PFN_W-1:0] wk_pfn;
    logic             wk_valid;
    logic             ins_en, hit_inc, miss_inc, accept, in_range;
    logic             unused_bits;

    assign req_vpn  = req_vaddr[VA_W-1:OFF_W];
    assign req_off  = req_vaddr[OFF_W-1:0];
    assign req_k    = acc_kind_e'(req_kind);
    assign wk_pfn   = pt_rd_data[PA_W-1:OFF_W];
    assign wk_perm  = pt_rd_data[3:1];
    assign wk_valid = pt_rd_data[0];
    assign unused_bits = ^pt_rd_data[OFF_W-1:4];
    assign accept   = req_valid && (u_q.st == S_IDLE);
    assign in_range = {1'b0, req_vpn} < pt_len;

    xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .ins_en(ins_en), .ins_vpn(u_q.vpn), .ins_pfn(wk_pfn), .ins_perm(wk_perm)
    );

    xlat_perm u_lk_perm (.kind(req_k),    .perm(lk_perm), .ok(lk_ok));
    xlat_perm u_wk_perm (.kind(u_q.kind), .perm(wk_perm), .ok(wk_ok));

    xlat_ctr #(.W(CNT_W)) u_hits   (.clk(clk), .rst_n(rst_n), .inc(hit_inc),  .count(hit_count));
    xlat_ctr #(.W(CNT_W)) u_misses (.clk(clk), .rst_n(rst_n), .inc(miss_inc), .count(miss_count));

    always_comb begin
        u_d      = u_q;
        u_d.rv   = 1'b0;
        ins_en   = 1'b0;
        hit_inc  = 1'b0;
        miss_inc = 1'b0;
        case (u_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    u_d.vpn  = req_vpn;
                    u_d.off  = req_off;
                    u_d.kind = req_k;
                    if (!in_range) begin
                        u_d.rv  = 1'b1;
                        u_d.flt = F_BOUND;
                        u_d.pa  = '0;
                    end else if (lk_hit) begin
                        hit_inc = 1'b1;
                        u_d.rv  = 1'b1;
                        u_d.flt = lk_ok ? F_NONE : F_RIGHTS;
                        u_d.pa  = lk_ok ? {lk_pfn, req_off} : '0;
                    end else begin
                        miss_inc   = 1'b1;
                        u_d.st     = S_WALK;
                        u_d.ptaddr = pt_base + (PA_W'(req_vpn) << 2);
                    end
                end
            end
            default: begin
                if (pt_rd_done) begin
                    u_d.st = S_IDLE;
                    u_d.rv = 1'b1;
                    if (!wk_valid) begin
                        u_d.flt = F_INVALID;
                        u_d.pa  = '0;
                    end else begin
                        ins_en  = 1'b1;
                        u_d.flt = wk_ok ? F_NONE : F_RIGHTS;
                        u_d.pa  = wk_ok ? {wk_pfn, u_q.off} : '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign req_ready   = (u_q.st == S_IDLE);
    assign rsp_valid   = u_q.rv;
    assign rsp_paddr   = u_q.pa;
    assign rsp_fault   = u_q.flt;
    assign pt_rd_valid = (u_q.st == S_WALK);
    assign pt_rd_addr  = u_q.ptaddr;

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_rd_valid && !pt_rd_done) |=> (pt_rd_valid && $stable(pt_rd_addr)));
    // R4
    bound_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> (rsp_valid && rsp_fault == F_BOUND && !pt_rd_valid));
    // R2
    hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_range && lk_hit) |=> (rsp_valid && !pt_rd_valid));
    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != F_NONE) |-> (rsp_paddr == '0));
    // R3
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pt_rd_valid) |-> $past(accept));
endmodule

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = 32'h0001_0000;
    logic [20:0] pt_len = 21'd64;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        pt_rd_valid;
    logic [31:0] pt_rd_addr;
    logic        pt_rd_done = 1'b0;
    logic [31:0] pt_rd_data = '0;
    logic [15:0] hit_count, miss_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_unit u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base), .pt_len(pt_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .pt_rd_valid(pt_rd_valid), .pt_rd_addr(pt_rd_addr), .pt_rd_done(pt_rd_done),
        .pt_rd_data(pt_rd_data), .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  flt;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] mem [int unsigned];

    logic [19:0] m_vpn [16];
    logic [31:0] m_pte [16];
    bit          m_v   [16];
    int          m_rr = 0;
    int          m_hits = 0;
    int          m_miss = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic set_pte(input logic [19:0] vpn, input logic [19:0] frame, input logic [3:0] flags);
        mem[pt_base + {vpn, 2'b00}] = {frame, 8'h00, flags};
    endtask

    function automatic bit allowed(input logic [31:0] pte, input logic [1:0] kind);
        case (kind)
            2'd0: return pte[1];
            2'd1: return pte[2];
            2'd2: return pte[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 16; i++) m_v[i] = 0;
    endtask

    task automatic access(input logic [19:0] vpn, input logic [11:0] off,
                          input logic [1:0] kind, input bit fl, input string tag);
        exp_t e;
        logic [31:0] pte;
        bit hit;
        int idx;
        e.tag = tag;
        if (fl) clear_model();
        if ({1'b0, vpn} >= pt_len) begin
            e.pa = '0; e.flt = 2'd1;
        end else begin
            hit = 0; idx = 0;
            for (int i = 0; i < 16; i++) if (m_v[i] && m_vpn[i] == vpn) begin hit = 1; idx = i; end
            if (hit) begin
                m_hits++;
                pte = m_pte[idx];
            end else begin
                m_miss++;
                pte = rd_mem(pt_base + {vpn, 2'b00});
                if (pte[0]) begin
                    m_v[m_rr] = 1; m_vpn[m_rr] = vpn; m_pte[m_rr] = pte;
                    m_rr = (m_rr + 1) % 16;
                end
            end
            if (!pte[0])                 begin e.pa = '0; e.flt = 2'd2; end
            else if (!allowed(pte, kind)) begin e.pa = '0; e.flt = 2'd3; end
            else                          begin e.pa = {pte[31:12], off}; e.flt = 2'd0; end
        end
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_kind  = kind;
        flush     = fl;
        @(negedge clk);
        req_valid = 1'b0;
        flush     = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic do_flush();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        flush = 1'b1;
        clear_model();
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic chk_counts(input string tag);
        chk(hit_count == 16'(m_hits), tag, "hit_count", 64'(hit_count), 64'(m_hits));
        chk(miss_count == 16'(m_miss), tag, "miss_count", 64'(miss_count), 64'(m_miss));
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", 64'(rsp_paddr), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_paddr == e.pa, e.tag, "paddr", 64'(rsp_paddr), 64'(e.pa));
                chk(rsp_fault == e.flt, e.tag, "fault", 64'(rsp_fault), 64'(e.flt));
            end
        end
    end

    // table memory model, two-cycle latency
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (pt_rd_done) begin
                pt_rd_done = 1'b0;
            end else if (pt_rd_valid) begin
                if (lat == 2) begin
                    pt_rd_data = rd_mem(pt_rd_addr);
                    pt_rd_done = 1'b1;
                    lat = 0;
                end else begin
                    lat++;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            chk(1'b0, "R2", "watchdog expired", 64'h0, 64'h1);
            summary();
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(rsp_valid == 1'b0, "R10", "rsp_valid", 64'(rsp_valid), 64'h0);
        chk(pt_rd_valid == 1'b0, "R10", "pt_rd_valid", 64'(pt_rd_valid), 64'h0);
        chk(req_ready == 1'b1, "R10", "req_ready", 64'(req_ready), 64'h1);
        chk_counts("R10");
        rst_n = 1'b1;

        set_pte(20'd5, 20'h00ABC, 4'b0011);   // read only
        set_pte(20'd6, 20'h00DDD, 4'b0010);   // not present
        set_pte(20'd7, 20'h12345, 4'b1001);   // execute only
        set_pte(20'd8, 20'h0F0F0, 4'b0111);   // read-write

        access(20'd5, 12'h123, 2'd0, 0, "R3");
        access(20'd5, 12'hFFF, 2'd0, 0, "R2");
        access(20'd5, 12'h000, 2'd0, 0, "R1");
        access(20'd5, 12'h456, 2'd1, 0, "R6");
        chk_counts("R9");
        access(20'd6, 12'h010, 2'd0, 0, "R5");
        access(20'd6, 12'h010, 2'd0, 0, "R5");
        chk_counts("R5");
        access(20'd64, 12'h001, 2'd0, 0, "R4");
        access(20'hFFFFF, 12'h001, 2'd2, 0, "R4");
        chk_counts("R4");
        access(20'd7, 12'hABC, 2'd2, 0, "R6");
        access(20'd7, 12'hABC, 2'd0, 0, "R6");
        access(20'd8, 12'h321, 2'd2, 0, "R6");
        access(20'd8, 12'h321, 2'd1, 0, "R6");
        access(20'd8, 12'h321, 2'd3, 0, "R6");

        // stale entry stays in use until flushed
        set_pte(20'd5, 20'h55555, 4'b0011);
        access(20'd5, 12'h008, 2'd0, 0, "R3");
        do_flush();
        access(20'd5, 12'h008, 2'd0, 0, "R7");
        chk_counts("R7");
        // flush in the same cycle as a lookup of a held page
        set_pte(20'd5, 20'h66666, 4'b0011);
        access(20'd5, 12'h00C, 2'd0, 1, "R7");
        chk_counts("R7");

        // new table base
        do_flush();
        pt_base = 32'h0002_0000;
        set_pte(20'd5, 20'h77777, 4'b0111);
        access(20'd5, 12'h9A0, 2'd1, 0, "R3");

        // round-robin eviction
        do_flush();
        for (int p = 10; p < 27; p++) set_pte(20'(p), 20'(p + 256), 4'b0011);
        for (int p = 10; p < 27; p++) access(20'(p), 12'h044, 2'd0, 0, "R8");
        set_pte(20'd26, 20'h0AAAA, 4'b0011);
        set_pte(20'd10, 20'h0BBBB, 4'b0011);
        access(20'd26, 12'h100, 2'd0, 0, "R8");
        access(20'd10, 12'h100, 2'd0, 0, "R8");
        chk_counts("R8");
        chk_counts("R9");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2", "pending responses", 64'(sb.size()), 64'h0);
        done_run = 1;
        summary();
    end
endmodule